// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Selected Watermarks

This block is a first-in first-out buffer of 64 words, each 36 bits wide. It sits between two clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. Each side has its own enable. The two clocks run freely and may be unrelated or the same clock. A push and a pop may happen in the same cycle.

Each side sees only flags made in its own domain. The write side gets full and almost-full. The read side gets empty and almost-empty. Each pointer crosses into the other domain as a Gray code through two flops. A flag that depends on the other side's progress therefore changes two edges of the observing clock after that progress.

While reset is held, a 2-bit select input picks the watermark distance used by both almost-flags. The chosen value stays in force until the next reset.

Top module: `dcfifo_preset`

## Requirements
- R1: Words leave in the order they were accepted, with their 36-bit values unchanged. `rd_data` is registered. It takes the next word on the read-clock edge at which `rd_en` is high and `empty` is low, and it holds its value otherwise.
- R2: The reset input `rst` is synchronous and active high, and it must be held for at least two edges of each clock. It returns both pointers to the first location. Out of reset, `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `rd_data`=0.
- R3: `empty` is high exactly when the read pointer equals the write pointer as seen in the read domain. A word accepted on write edge k makes `empty` fall after the second read edge that follows the crossing, which is edge k+2 when the clocks are the same.
- R4: `full` is high exactly when 64 words are held as seen in the write domain. A pop becomes visible to `full` two write edges later.
- R5: A push while `full` is high is dropped, and a pop while `empty` is high is dropped. Neither moves a pointer, so a dropped word never appears at `rd_data`, and `rd_data` keeps its value.
- R6: `offset_sel`, as sampled on the last edge with `rst` high, sets the watermark. The encoding is 2'b00 = 16, 2'b01 = 12, 2'b10 = 8 and 2'b11 = 4 words.
- R7: `almost_empty` is high when the read-side word count is at or below the watermark. The read-side count is the synchronized write pointer minus the read pointer.
- R8: `almost_full` is high when the free space is at or below the watermark. The free space is 64 minus the write-side count, where the write-side count is the write pointer minus the synchronized read pointer.
- R9: Changing `offset_sel` while `rst` is low has no effect on either almost-flag.
- R10: A push and a pop in the same cycle are both accepted when their flags allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| offset_sel | input | 2 | Watermark select, captured during reset |
| wr_en | input | 1 | Push request |
| wr_data | input | 36 | Word to push |
| full | output | 1 | No free entry (write domain) |
| almost_full | output | 1 | Free space at or below the watermark (write domain) |
| rd_en | input | 1 | Pop request |
| rd_data | output | 36 | Last popped word |
| empty | output | 1 | No word available (read domain) |
| almost_empty | output | 1 | Stored count at or below the watermark (read domain) |

## Verification
The bench drives both clocks from one source so that every latency is an exact edge count. `rd_data` is due one edge after an accepted pop. `full` and `almost_full` react to a push on the same edge, but they react to a pop only two edges later. `empty` and `almost_empty` react to a pop on the same edge and to a push two edges later. The reference model keeps two-deep histories of the push and pop totals to reproduce these delays. The bench drives inputs and compares every output at the falling edge, so each value is checked after the rising edge that produced it has settled.

// File: rtl/dcfifo_preset.sv
module dcfifo_preset #(
  parameter int DW   = 36,
  parameter int AW   = 6,
  parameter int STEP = 4
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic [1:0]    offset_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] sel2off(input logic [1:0] s);
    return PW'(STEP * (4 - int'(s)));
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rq1, rq2, w_off, wfill;
  logic          w_do;

  assign w_do  = wr_en & ~full & ~rst;
  assign full  = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  assign wfill = wbin - g2b(rq2);
  assign almost_full = (PW'(DEPTH) - wfill) <= w_off;

  always_ff @(posedge wr_clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
      w_off <= sel2off(offset_sel);
    end else begin
      if (w_do) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
      rq1 <= rgray;
      rq2 <= rq1;
    end
  end

  always_ff @(posedge wr_clk)
    if (w_do) mem[wbin[AW-1:0]] <= wr_data;

  // read domain
  logic [PW-1:0] rbin, rgray, wq1, wq2, r_off, rfill;
  logic          r_do;

  assign r_do  = rd_en & ~empty & ~rst;
  assign empty = (rgray == wq2);
  assign rfill = g2b(wq2) - rbin;
  assign almost_empty = rfill <= r_off;

  always_ff @(posedge rd_clk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      wq1     <= '0;
      wq2     <= '0;
      r_off   <= sel2off(offset_sel);
      rd_data <= '0;
    end else begin
      if (r_do) begin
        rbin    <= rbin + 1'b1;
        rgray   <= b2g(rbin + 1'b1);
        rd_data <= mem[rbin[AW-1:0]];
      end
      wq1 <= wgray;
      wq2 <= wq1;
    end
  end

  // assertions
  a_r5_no_push_when_full: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en && full) |=> (wbin == $past(wbin)));
  a_r5_no_pop_when_empty: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_en && empty) |=> (rbin == $past(rbin) && $stable(rd_data)));
  a_r8_full_is_almost_full: assert property (@(posedge wr_clk) disable iff (rst)
    full |-> almost_full);
  a_r7_empty_is_almost_empty: assert property (@(posedge rd_clk) disable iff (rst)
    empty |-> almost_empty);
  a_r9_wr_offset_held: assert property (@(posedge wr_clk) disable iff (rst)
    1'b1 |=> (rst || w_off == $past(w_off)));
  a_r9_rd_offset_held: assert property (@(posedge rd_clk) disable iff (rst)
    1'b1 |=> (rst || r_off == $past(r_off)));
  a_r3_wgray_one_step: assert property (@(posedge wr_clk) disable iff (rst)
    1'b1 |=> (rst || $onehot0(wgray ^ $past(wgray))));
  a_r4_rgray_one_step: assert property (@(posedge rd_clk) disable iff (rst)
    1'b1 |=> (rst || $onehot0(rgray ^ $past(rgray))));
endmodule

// File: tb/dcfifo_preset_tb.sv
module dcfifo_preset_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  offset_sel = 2'b00;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic        full, almost_full, empty, almost_empty;
  logic [35:0] rd_data;

  always #2 clk = ~clk;

  dcfifo_preset dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst(rst), .offset_sel(offset_sel),
    .wr_en(wr_en), .wr_data(wr_data), .full(full), .almost_full(almost_full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty)
  );

  int checks = 0, fails = 0, seq = 0;
  int wtot, rtot, wh1, wh2, rh1, rh2, off;
  logic [35:0] q[$];
  logic [35:0] exp_rd;
  bit done = 0;

  function automatic bit e_full();   return (wtot - rh2) == 64;        endfunction
  function automatic bit e_empty();  return wh2 == rtot;               endfunction
  function automatic bit e_afull();  return (64 - (wtot - rh2)) <= off; endfunction
  function automatic bit e_aempty(); return (wh2 - rtot) <= off;       endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string dtag);
    chk({dtag, " rd_data"}, rd_data, exp_rd);
    chk("R3 empty", 36'(empty), 36'(e_empty()));
    chk("R4 full", 36'(full), 36'(e_full()));
    chk("R7 R6 almost_empty", 36'(almost_empty), 36'(e_aempty()));
    chk("R8 R6 almost_full", 36'(almost_full), 36'(e_afull()));
  endtask

  task automatic step(input bit we, input bit re, input string dtag);
    bit wacc, racc;
    logic [35:0] wd;
    wd = {4'hA, 32'(seq)};
    seq++;
    wr_en = we; wr_data = wd; rd_en = re;
    wacc = we && !e_full();
    racc = re && !e_empty();
    wh2 = wh1; wh1 = wtot; rh2 = rh1; rh1 = rtot;
    if (wacc) begin q.push_back(wd); wtot++; end
    if (racc) begin exp_rd = q.pop_front(); rtot++; end
    @(negedge clk);
    compare_all(dtag);
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst = 1'b1; offset_sel = s; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    wtot = 0; rtot = 0; wh1 = 0; wh2 = 0; rh1 = 0; rh2 = 0;
    off = 16 - 4 * int'(s);
    q.delete();
    exp_rd = '0;
    chk("R2 empty", 36'(empty), 36'(1));
    chk("R2 almost_empty", 36'(almost_empty), 36'(1));
    chk("R2 full", 36'(full), 36'(0));
    chk("R2 almost_full", 36'(almost_full), 36'(0));
    chk("R2 rd_data", rd_data, 36'(0));
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      step(1'b0, 1'b1, "R5");
      for (int i = 0; i < 70; i++) step(1'b1, 1'b0, "R1");
      offset_sel = ~offset_sel;
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R9");
      for (int i = 0; i < 72; i++) step(1'b0, 1'b1, "R5");
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "R1");
      for (int i = 0; i < 60; i++) step(1'b1, 1'b1, "R10");
      for (int i = 0; i < 200; i++)
        step(1'(($urandom % 4) != 0), 1'(($urandom % 3) != 0), "R10");
      for (int i = 0; i < 80; i++) step(1'b0, 1'b1, "R1");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule